// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is the receive side of an I2C target device. It watches the SCL and SDA lines through a two-flop synchroniser and recognises START and STOP conditions. It compares the first byte after START with a programmable 7-bit address, and it shifts in each data byte that follows, most significant bit first. It acknowledges the address and each data byte by pulling SDA low during the ninth clock. Received bytes go into a small queue that a host drains through a byte-wide register interface. Only write transfers are accepted.

Software chooses how many received bytes may wait before the bus is paused. In double-buffer mode two bytes may be pending. In single-buffer mode only one may be pending. When the host falls behind, the block holds SCL low, which stretches the clock. It lets SCL go within one system clock of the host acknowledging a byte. Both lines are modelled as open-drain enables: a 1 on an `_oe` output pulls that line low. A slave-enable bit keeps the whole receive path in reset while it is 0. A master-enable bit, when written with 1, clears that slave-enable bit.

Register map, selected by `reg_addr`:
- 0, slave control: bit 0 acknowledges the general-call address, bit 1 enables the slave, bit 2 selects single-buffer mode (0 selects double-buffer mode). Bits 7:3 always read 0.
- 1, own address: bits 6:0. Bit 7 reads 0.
- 2, status: bit 0 is the data-ready flag. Writing 1 to bit 0 clears the flag and removes the oldest byte from the queue.
- 3, receive data: the oldest queued byte (read only).
- 4, master control: bit 0 is the master-enable bit.

Top module: `i2c_stretch_rx`

## Requirements
- R1: After reset, the slave control register reads 0x00, status reads 0x00, own address reads 0x2A, and `scl_oe` and `sda_oe` are both 0.
- R2: Bits 7:3 of the slave control register read 0 whatever value was written. Writing 0xFF reads back as 0x07.
- R3: An address byte whose upper seven bits equal the own address and whose R/W bit (bit 0) is 0 is acknowledged, with SDA low during the ninth clock. An address that differs, or one with R/W equal to 1, is not acknowledged, and the data bytes that follow it are neither acknowledged nor stored.
- R4: The general-call address 0x00 is acknowledged when control bit 0 is 1 and is ignored when it is 0.
- R5: After an accepted address, each data byte is acknowledged and stored MSB first. The data register shows the oldest stored byte, and the data-ready flag is 1 while any byte is stored.
- R6: In double-buffer mode (control bit 2 = 0), one pending byte causes no stretch. When a second byte fills the queue, SCL is held low from the start of its acknowledge clock until the host clears the flag. SCL is released in the cycle after the clearing write, and the flag then stays 1 with the second byte in the data register.
- R7: In single-buffer mode (control bit 2 = 1), SCL is held low at the acknowledge clock after every received byte until the host clears the flag. It is released in the cycle after the clearing write.
- R8: A STOP condition returns the slave to idle and discards all stored bytes, so the data-ready flag reads 0.
- R9: While the slave-enable bit (control bit 1) is 0, no address is acknowledged, no byte is stored, any stored bytes are discarded, and neither line is pulled low.
- R10: Writing 1 to master-control bit 0 clears the slave-enable bit. Master-control bit 0 reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| data_ready | output | 1 | At least one received byte is waiting |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |

## Verification
Each bus edge reaches the receive logic three system clocks after it occurs on the line: two synchroniser flops, then an edge-detect register. A stored byte and the acknowledge drive therefore appear a few cycles after the eighth SCL rise or the following SCL fall. The bench's bit-banged master holds every bus phase for ten clocks, so it samples the acknowledge and data-ready well after they have settled. A register write takes effect at the next rising edge, and the SCL release it causes is sampled at the falling edge right after that. This makes the one-cycle release bound exact. The stretch itself is observed as the SCL line staying low 40 clocks after the master has let go of it.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 7;

   localparam logic [2:0] REG_SCTL = 3'd0;
   localparam logic [2:0] REG_OWN  = 3'd1;
   localparam logic [2:0] REG_STAT = 3'd2;
   localparam logic [2:0] REG_DATA = 3'd3;
   localparam logic [2:0] REG_MCTL = 3'd4;

   typedef enum logic [1:0] {
      LK_IDLE,
      LK_ADDR,
      LK_DATA,
      LK_SKIP
   } link_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cs_sync needs at least two stages");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= RST_VAL;
            else if (g == 0) stage[g] <= d;
            else stage[g] <= stage[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/i2cs_rxbuf.sv
module i2cs_rxbuf #(
   parameter int DEPTH = 2,
   parameter int W     = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic          do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop && (count != '0);
   assign head    = mem[rd_ptr];

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   // R6: the stretch rule must keep a new byte from arriving while the queue is full
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush) |-> (count != CW'(DEPTH)));
endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
   import i2cs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              gc_en,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              stretch_cond,
   input  logic              scl_s,
   input  logic              sda_s,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              stop_det,
   output logic              scl_oe,
   output logic              sda_oe
);
   logic        scl_d, sda_d;
   logic        scl_rise, scl_fall, start_c, stop_c;
   link_state_e state;
   logic [3:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic        ack_pend, ack_q, hold_q;
   logic [DATA_W-1:0] byte_in;
   logic        addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

   assign byte_in  = {shreg[DATA_W-2:0], sda_s};
   assign addr_hit = ((byte_in[DATA_W-1:1] == own_addr) && !byte_in[0]) ||
                     ((byte_in == '0) && gc_en);

   assign push      = en && !start_c && !stop_c && scl_rise &&
                      (state == LK_DATA) && (bit_cnt == 4'd7);
   assign push_data = byte_in;
   assign stop_det  = en && stop_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= LK_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         ack_pend <= 1'b0;
         ack_q    <= 1'b0;
         hold_q   <= 1'b0;
      end else if (!en || stop_c) begin
         state    <= LK_IDLE;
         bit_cnt  <= '0;
         ack_pend <= 1'b0;
         ack_q    <= 1'b0;
         hold_q   <= 1'b0;
      end else if (start_c) begin
         state    <= LK_ADDR;
         bit_cnt  <= '0;
         ack_pend <= 1'b0;
         ack_q    <= 1'b0;
         hold_q   <= 1'b0;
      end else begin
         if (scl_rise && state != LK_IDLE) begin
            shreg   <= byte_in;
            bit_cnt <= (bit_cnt == 4'd8) ? 4'd0 : bit_cnt + 4'd1;
            if (bit_cnt == 4'd7) begin
               if (state == LK_ADDR) begin
                  ack_pend <= addr_hit;
                  state    <= addr_hit ? LK_DATA : LK_SKIP;
               end else if (state == LK_DATA) begin
                  ack_pend <= 1'b1;
               end
            end
         end
         if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
               ack_q    <= ack_pend;
               ack_pend <= 1'b0;
            end else if (bit_cnt == 4'd0) begin
               ack_q <= 1'b0;
            end
            if (stretch_cond && state != LK_IDLE) hold_q <= 1'b1;
         end
         if (!stretch_cond) hold_q <= 1'b0;
      end
   end

   assign scl_oe = hold_q && stretch_cond;
   assign sda_oe = ack_q;

   // R3: the acknowledge is only ever applied while SCL is low
   a_r3_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/i2c_stretch_rx.sv
module i2c_stretch_rx
   import i2cs_pkg::*;
#(
   parameter int               SYNC_STAGES  = 2,
   parameter int               BUF_DEPTH    = 2,
   parameter logic [ADDR_W-1:0] OWN_ADDR_RST = 7'h2A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [2:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       data_ready,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe
);
   localparam int CW = $clog2(BUF_DEPTH + 1);

   generate
      if (BUF_DEPTH < 2) begin : g_bad_depth
         $error("i2c_stretch_rx needs a receive queue of at least two bytes");
      end
   endgenerate

   logic              gc_en, slave_en, single_buf, master_en;
   logic [ADDR_W-1:0] own_addr;
   logic [1:0]        lines_s;
   logic              push, stop_det, pop, stretch_cond;
   logic [DATA_W-1:0] push_data, head;
   logic [CW-1:0]     buf_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gc_en      <= 1'b0;
         slave_en   <= 1'b0;
         single_buf <= 1'b0;
         master_en  <= 1'b0;
         own_addr   <= OWN_ADDR_RST;
      end else if (reg_wr) begin
         case (reg_addr)
            REG_SCTL: {single_buf, slave_en, gc_en} <= reg_wdata[2:0];
            REG_OWN:  own_addr <= reg_wdata[ADDR_W-1:0];
            REG_MCTL: begin
               master_en <= reg_wdata[0];
               if (reg_wdata[0]) slave_en <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign pop        = reg_wr && (reg_addr == REG_STAT) && reg_wdata[0];
   assign data_ready = (buf_cnt != '0);

   always_comb begin
      case (reg_addr)
         REG_SCTL: reg_rdata = {5'b0, single_buf, slave_en, gc_en};
         REG_OWN:  reg_rdata = {1'b0, own_addr};
         REG_STAT: reg_rdata = {7'b0, data_ready};
         REG_DATA: reg_rdata = head;
         REG_MCTL: reg_rdata = {7'b0, master_en};
         default:  reg_rdata = '0;
      endcase
   end

   assign stretch_cond = single_buf ? (buf_cnt != '0) : (buf_cnt == CW'(BUF_DEPTH));

   i2cs_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (lines_s)
   );

   i2cs_link u_link (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (slave_en),
      .gc_en        (gc_en),
      .own_addr     (own_addr),
      .stretch_cond (stretch_cond),
      .scl_s        (lines_s[1]),
      .sda_s        (lines_s[0]),
      .push         (push),
      .push_data    (push_data),
      .stop_det     (stop_det),
      .scl_oe       (scl_oe),
      .sda_oe       (sda_oe)
   );

   i2cs_rxbuf #(.DEPTH(BUF_DEPTH), .W(DATA_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (stop_det || !slave_en),
      .push      (push),
      .push_data (push_data),
      .pop       (pop),
      .head      (head),
      .count     (buf_cnt)
   );

   // R8: a STOP leaves the queue empty
   a_r8_stop_empties: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (buf_cnt == '0));
   // R9: a disabled slave pulls neither line
   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_en |=> (!sda_oe && !scl_oe));
   // R6: clearing the flag in double-buffer mode frees SCL one cycle later
   a_r6_pop_release: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !single_buf) |=> !scl_oe);
   // R7: SCL is only stretched while a byte is waiting
   a_r7_stretch_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe |-> data_ready);
endmodule

// File: tb/i2c_stretch_rx_tb.sv
module i2c_stretch_rx_tb;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       data_ready, scl_oe, sda_oe;
   logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic       scl_line, sda_line;
   int         checks = 0, failures = 0, cyc = 0;

   always #5 clk = ~clk;

   assign scl_line = !(m_scl_low || scl_oe);
   assign sda_line = !(m_sda_low || sda_oe);

   i2c_stretch_rx u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_ready(data_ready),
      .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog expired: actual=%0d expected<=150000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_scl_high(output int waited);
      waited = 0;
      while (!scl_line && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0; m_scl_low = 1'b0;
      wait_q();
      m_sda_low = 1'b1;
      wait_q();
      m_scl_low = 1'b1;
      wait_q();
   endtask

   task automatic bus_stop();
      int w;
      m_sda_low = 1'b1;
      wait_q();
      m_scl_low = 1'b0;
      wait_scl_high(w);
      wait_q();
      m_sda_low = 1'b0;
      wait_q();
   endtask

   task automatic send_bits(input logic [7:0] b);
      int w;
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = !b[i];
         wait_q();
         m_scl_low = 1'b0;
         wait_scl_high(w);
         wait_q();
         m_scl_low = 1'b1;
         wait_q();
      end
   endtask

   task automatic ack_open();
      m_sda_low = 1'b0;
      wait_q();
      m_scl_low = 1'b0;
   endtask

   task automatic ack_close(output logic ack, output int waited);
      wait_scl_high(waited);
      repeat (Q/2) @(negedge clk);
      ack = !sda_line;
      repeat (Q/2) @(negedge clk);
      m_scl_low = 1'b1;
      wait_q();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack, output int waited);
      send_bits(b);
      ack_open();
      ack_close(ack, waited);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      reg_read(3'd0, v); check_eq("R1 control reset", v, 8'h00);
      reg_read(3'd2, v); check_eq("R1 status reset", v, 8'h00);
      reg_read(3'd1, v); check_eq("R1 own address reset", v, 8'h2A);
      check_eq("R1 oe reset", {scl_oe, sda_oe}, 2'b00);
   endtask

   task automatic t_reserved();
      logic [7:0] v;
      reg_write(3'd0, 8'hFF);
      reg_read(3'd0, v); check_eq("R2 reserved bits read zero", v, 8'h07);
      reg_write(3'd0, 8'h02);
   endtask

   task automatic t_mismatch();
      logic ack; int w; logic [7:0] v;
      bus_start();
      send_byte(8'h66, ack, w); check_eq("R3 foreign address not acked", ack, 1'b0);
      send_byte(8'h99, ack, w); check_eq("R3 data after foreign address not acked", ack, 1'b0);
      bus_stop();
      reg_read(3'd2, v); check_eq("R3 nothing stored after mismatch", v, 8'h00);
      bus_start();
      send_byte(8'h55, ack, w); check_eq("R3 read request not acked", ack, 1'b0);
      bus_stop();
   endtask

   task automatic t_double();
      logic ack; int w; logic [7:0] v;
      reg_write(3'd0, 8'h02);
      bus_start();
      send_byte(8'h54, ack, w); check_eq("R3 own address acked", ack, 1'b1);
      send_byte(8'hA5, ack, w);
      check_eq("R5 data byte acked", ack, 1'b1);
      check_eq("R6 no stretch with one byte", (w < 5), 1'b1);
      reg_read(3'd3, v); check_eq("R5 data register", v, 8'hA5);
      check_eq("R5 data ready", data_ready, 1'b1);
      send_bits(8'h3C);
      ack_open();
      repeat (40) @(negedge clk);
      check_eq("R6 SCL held low with queue full", scl_line, 1'b0);
      reg_read(3'd3, v); check_eq("R6 oldest byte shown while held", v, 8'hA5);
      reg_write(3'd2, 8'h01);
      check_eq("R6 SCL released one cycle after clear", scl_oe, 1'b0);
      reg_read(3'd3, v); check_eq("R6 second byte after pop", v, 8'h3C);
      check_eq("R6 flag stays set after pop", data_ready, 1'b1);
      ack_close(ack, w); check_eq("R6 second byte acked", ack, 1'b1);
      reg_write(3'd2, 8'h01);
      check_eq("R5 flag clear when empty", data_ready, 1'b0);
      bus_stop();
   endtask

   task automatic t_single();
      logic ack; int w; logic [7:0] v;
      reg_write(3'd0, 8'h06);
      bus_start();
      send_byte(8'h54, ack, w);
      for (int k = 0; k < 2; k++) begin
         logic [7:0] b;
         b = (k == 0) ? 8'h81 : 8'h7E;
         send_bits(b);
         ack_open();
         repeat (40) @(negedge clk);
         check_eq("R7 SCL held after single byte", scl_line, 1'b0);
         reg_read(3'd3, v); check_eq("R7 byte captured", v, b);
         reg_write(3'd2, 8'h01);
         check_eq("R7 SCL released one cycle after clear", scl_oe, 1'b0);
         ack_close(ack, w); check_eq("R7 byte acked", ack, 1'b1);
      end
      bus_stop();
      reg_write(3'd0, 8'h02);
   endtask

   task automatic t_stop_flush();
      logic ack; int w; logic [7:0] v;
      bus_start();
      send_byte(8'h54, ack, w);
      send_byte(8'h12, ack, w);
      check_eq("R8 byte pending before stop", data_ready, 1'b1);
      bus_stop();
      reg_read(3'd2, v); check_eq("R8 stop discards bytes", v, 8'h00);
   endtask

   task automatic t_gcall();
      logic ack; int w; logic [7:0] v;
      reg_write(3'd0, 8'h02);
      bus_start();
      send_byte(8'h00, ack, w); check_eq("R4 general call ignored when disabled", ack, 1'b0);
      bus_stop();
      reg_write(3'd0, 8'h03);
      bus_start();
      send_byte(8'h00, ack, w); check_eq("R4 general call acked when enabled", ack, 1'b1);
      send_byte(8'h5A, ack, w);
      reg_read(3'd3, v); check_eq("R4 general call data stored", v, 8'h5A);
      reg_write(3'd2, 8'h01);
      bus_stop();
      reg_write(3'd0, 8'h02);
   endtask

   task automatic t_disable();
      logic ack; int w; logic [7:0] v;
      bus_start();
      send_byte(8'h54, ack, w);
      send_byte(8'h11, ack, w);
      check_eq("R9 byte stored while enabled", data_ready, 1'b1);
      reg_write(3'd0, 8'h00);
      reg_read(3'd2, v); check_eq("R9 disable discards bytes", v, 8'h00);
      bus_stop();
      bus_start();
      send_byte(8'h54, ack, w); check_eq("R9 no ack while disabled", ack, 1'b0);
      send_byte(8'h22, ack, w);
      check_eq("R9 no store while disabled", data_ready, 1'b0);
      bus_stop();
   endtask

   task automatic t_master();
      logic [7:0] v;
      reg_write(3'd0, 8'h03);
      reg_write(3'd4, 8'h01);
      reg_read(3'd0, v); check_eq("R10 master enable clears slave enable", v, 8'h01);
      reg_read(3'd4, v); check_eq("R10 master enable reads back", v, 8'h01);
      reg_write(3'd4, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_reserved();
      t_mismatch();
      t_double();
      t_single();
      t_stop_flush();
      t_gcall();
      t_disable();
      t_master();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule